// File: doc/BRIEF.md
# Inbound Message Mailbox with Data Interrupt

The block collects single-word replies from several channel sources into a small first-in first-out queue. A host processor drains that queue through a 32-bit register port. Each source presents a word with a valid flag. The mailbox takes at most one word per clock, always from the lowest-numbered source that has one, whenever the queue has room. The host reads the oldest word and removes it in one access. It can also look at the oldest word without removing it, read a status word that shows the fill level and the full and empty flags, and read or write a small configuration word.

A read that removes from an empty queue does not stall. It returns the marker 0xFFFFFFFF and leaves all state as it was. One level interrupt line is raised while the queue holds data and the host has enabled the interrupt. The pending flag follows the not-empty state directly, so draining the queue is the only way to clear it.

Source handshake rules: the block drives `ch_ready` for one cycle for each word it takes, and only toward a source whose `ch_valid` is high. A word is transferred on a clock edge where both are high. The source then presents its next word, or drops `ch_valid`, before the following edge. A source is never offered `ch_ready` while the queue is full, unless the host removes a word in that same cycle. `ch_data` must stay stable while `ch_valid` is high and no ready has been given.

Top module: `mbx_inbound`

## Requirements
- R1: After reset the queue is empty, the config word reads 0, `irq` is low, and every queue slot holds 0xFFFFFFFF.
- R2: A full-word read at byte offset 0x80, 0x84, 0x88 or 0x8C returns the oldest word and removes it. Words leave in the order they were collected.
- R3: A removing read while the queue is empty returns 0xFFFFFFFF and changes no state.
- R4: A read at offset 0x90 returns the oldest word without removing it. When the queue is empty it returns 0xFFFFFFFF, because vacated slots are refilled with that marker.
- R5: A read at offset 0x98 returns status: bit 31 set when the level equals the depth (8), bit 30 set when the level is 0, bits 7:0 the level, other bits 0.
- R6: A read at offset 0x9C returns config: bit 0 is the interrupt enable, bit 4 is the pending flag (queue not empty), other bits 0. A write at 0x9C stores only bit 0 of the write data.
- R7: `irq` is high exactly when the pending flag and the enable are both set.
- R8: While the queue has room, `ch_ready` is given to the lowest-indexed source with `ch_valid` high, at most one source per cycle, and never to a source without `ch_valid`.
- R9: With the queue full, no `ch_ready` is given unless a removing host read happens in the same cycle. In that case one word is collected and the level stays at the depth.
- R10: Reads of any other offset return 0 and writes to any offset other than 0x9C change nothing.
- R11: An access whose byte enables are not all set (`reg_be` != 4'hF) is ignored. It reads 0 and neither removes a word nor changes config.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Host read strobe, one access per cycle |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for the access in the same cycle; 0 when not reading |
| ch_valid | input | N_CH | Per-source word available |
| ch_data | input | N_CH*32 | Per-source word, source i in bits 32*i+31:32*i |
| ch_ready | output | N_CH | One-cycle take strobe toward a source |
| irq | output | 1 | Level interrupt: data waiting and enabled |

## Verification
Collecting a source word and a host removal can fall in the same cycle. The case that matters is the one where the queue is full. The bench loads one source with more words than the queue holds and waits until the queue fills and `ch_ready` drops. It then issues removing reads on consecutive cycles. A reference model in the bench, advanced at the same edges, predicts for each cycle which source gets ready and which word each removing read must return. The status reads that follow must show the level pinned at 8 until the source runs dry.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_POP,
    ACC_PEEK,
    ACC_STAT,
    ACC_CFG
  } mbx_acc_e;

  localparam logic [7:0] OFF_PEEK = 8'h90;
  localparam logic [7:0] OFF_STAT = 8'h98;
  localparam logic [7:0] OFF_CFG  = 8'h9C;
  localparam logic [3:0] POP_HI   = 4'h8;

  localparam int STAT_FULL_BIT  = 31;
  localparam int STAT_EMPTY_BIT = 30;
  localparam int CFG_EN_BIT     = 0;
  localparam int CFG_PEND_BIT   = 4;

  function automatic mbx_acc_e mbx_decode(input logic [7:0] off);
    mbx_acc_e a;
    if (off[7:4] == POP_HI && off[1:0] == 2'b00) a = ACC_POP;
    else if (off == OFF_PEEK)                    a = ACC_PEEK;
    else if (off == OFF_STAT)                    a = ACC_STAT;
    else if (off == OFF_CFG)                     a = ACC_CFG;
    else                                         a = ACC_NONE;
    return a;
  endfunction

endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int          W       = 32,
  parameter int          DEPTH   = 8,
  parameter logic [W-1:0] INVALID = '1,
  localparam int         CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  slot     [DEPTH];
  logic [W-1:0]  slot_nxt [DEPTH];
  logic [CW-1:0] level_q;
  logic [CW-1:0] level_nxt;
  logic [CW-1:0] wr_idx;

  // Write slot: the tail, moved down one when a removal shifts the queue.
  assign wr_idx = pop ? level_q - CW'(1) : level_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop) slot_nxt[i] = (i < DEPTH - 1) ? slot[(i < DEPTH - 1) ? i + 1 : i] : INVALID;
      else     slot_nxt[i] = slot[i];
      if (push && wr_idx == CW'(i)) slot_nxt[i] = push_data;
    end
    level_nxt = level_q;
    if (push && !pop)      level_nxt = level_q + CW'(1);
    else if (pop && !push) level_nxt = level_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= INVALID;
    end else begin
      level_q <= level_nxt;
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot_nxt[i];
    end
  end

  assign head  = slot[0];
  assign level = level_q;
  assign full  = (level_q == CW'(DEPTH));
  assign empty = (level_q == '0);

endmodule

// File: rtl/mbx_pick.sv
module mbx_pick #(
  parameter int N = 4
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [N-1:0] seen;

  // Fixed priority: index 0 wins; 'seen' marks a lower requester.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_prio
      if (g == 0) begin : g_first
        assign seen[g] = 1'b0;
      end else begin : g_rest
        assign seen[g] = seen[g-1] | req[g-1];
      end
      assign gnt[g] = en & req[g] & ~seen[g];
    end
  endgenerate

endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int           W       = 32,
  parameter int           CW      = 4,
  parameter logic [W-1:0] INVALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [3:0]    reg_be,
  input  logic          wr_en_bit,
  input  logic [W-1:0]  head,
  input  logic [CW-1:0] level,
  input  logic          full,
  input  logic          empty,
  output logic [W-1:0]  rdata,
  output logic          host_pop,
  output logic          cfg_en
);

  mbx_acc_e acc;
  logic     whole;
  logic [W-1:0] stat_w;
  logic [W-1:0] cfg_w;

  assign whole    = (reg_be == 4'hF);
  assign acc      = whole ? mbx_decode(reg_addr) : ACC_NONE;
  assign host_pop = reg_rd && acc == ACC_POP && !empty;

  always_comb begin
    stat_w                 = '0;
    stat_w[STAT_FULL_BIT]  = full;
    stat_w[STAT_EMPTY_BIT] = empty;
    stat_w[7:0]            = 8'(level);
    cfg_w                  = '0;
    cfg_w[CFG_EN_BIT]      = cfg_en;
    cfg_w[CFG_PEND_BIT]    = !empty;
  end

  always_comb begin
    rdata = '0;
    if (reg_rd) begin
      unique case (acc)
        ACC_POP:  rdata = empty ? INVALID : head;
        ACC_PEEK: rdata = head;
        ACC_STAT: rdata = stat_w;
        ACC_CFG:  rdata = cfg_w;
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         cfg_en <= 1'b0;
    else if (reg_wr && acc == ACC_CFG)  cfg_en <= wr_en_bit;
  end

endmodule

// File: rtl/mbx_inbound.sv
module mbx_inbound #(
  parameter int              DATA_W  = 32,
  parameter int              DEPTH   = 8,
  parameter int              N_CH    = 4,
  parameter logic [DATA_W-1:0] INVALID = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [7:0]               reg_addr,
  input  logic [3:0]               reg_be,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [N_CH-1:0]          ch_valid,
  input  logic [N_CH*DATA_W-1:0]   ch_data,
  output logic [N_CH-1:0]          ch_ready,
  output logic                     irq
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] head;
  logic [CW-1:0]     q_level;
  logic              q_full;
  logic              q_empty;
  logic              host_pop;
  logic              cfg_en;
  logic              room;
  logic              push;
  logic [DATA_W-1:0] push_data;

  // A removal in this cycle frees a slot for a word taken in the same cycle.
  assign room = !q_full || host_pop;

  mbx_pick #(.N(N_CH)) u_pick (
    .en  (room),
    .req (ch_valid),
    .gnt (ch_ready)
  );

  assign push = |ch_ready;

  always_comb begin
    push_data = '0;
    for (int i = 0; i < N_CH; i++)
      if (ch_ready[i]) push_data = push_data | ch_data[i*DATA_W +: DATA_W];
  end

  mbx_queue #(.W(DATA_W), .DEPTH(DEPTH), .INVALID(INVALID)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (host_pop),
    .head      (head),
    .level     (q_level),
    .full      (q_full),
    .empty     (q_empty)
  );

  mbx_regs #(.W(DATA_W), .CW(CW), .INVALID(INVALID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .wr_en_bit (reg_wdata[0]),
    .head      (head),
    .level     (q_level),
    .full      (q_full),
    .empty     (q_empty),
    .rdata     (reg_rdata),
    .host_pop  (host_pop),
    .cfg_en    (cfg_en)
  );

  assign irq = !q_empty && cfg_en;

endmodule

// File: rtl/mbx_inbound_chk.sv
module mbx_inbound_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int N_CH   = 4,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [7:0]        reg_addr,
  input logic [3:0]        reg_be,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [N_CH-1:0]   ch_valid,
  input logic [N_CH-1:0]   ch_ready,
  input logic              irq,
  input logic [CW-1:0]     level,
  input logic              host_pop,
  input logic              cfg_en
);

  logic pop_addr;
  assign pop_addr = reg_rd && reg_be == 4'hF && reg_addr[7:4] == 4'h8 && reg_addr[1:0] == 2'b00;

  // R8
  a_r8_single_ready: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_ready));
  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n) (ch_ready & ~ch_valid) == '0);
  // R9
  a_r9_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && !host_pop) |-> ch_ready == '0);
  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n) level <= CW'(DEPTH));
  // R3
  a_r3_empty_read_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_addr && level == '0) |-> reg_rdata == '1);
  // R2
  a_r2_pop_drops_level: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && ch_ready == '0) |=> level == $past(level) - CW'(1));
  // R7
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |-> !irq);
  a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n) irq |-> level != '0);

endmodule

bind mbx_inbound mbx_inbound_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .N_CH(N_CH), .CW($clog2(DEPTH + 1))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_be    (reg_be),
  .reg_rdata (reg_rdata),
  .ch_valid  (ch_valid),
  .ch_ready  (ch_ready),
  .irq       (irq),
  .level     (q_level),
  .host_pop  (host_pop),
  .cfg_en    (cfg_en)
);

// File: tb/tb_mbx_inbound.sv
module tb_mbx_inbound;

  localparam int NC = 4;
  localparam int DP = 8;
  localparam int SD = 16;
  localparam logic [31:0] INV = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] ch_valid = '0;
  logic [NC*32-1:0] ch_data = '0;
  logic [NC-1:0] ch_ready;
  logic irq;

  always #2 clk = ~clk;

  mbx_inbound dut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] src [NC][SD];
  int src_wp [NC];
  int src_rp [NC];
  logic [31:0] exp_q [$];
  bit en_m = 0;
  int took = -1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refresh();
    for (int i = 0; i < NC; i++) begin
      ch_valid[i] = (src_wp[i] != src_rp[i]);
      ch_data[i*32 +: 32] = ch_valid[i] ? src[i][src_rp[i] % SD] : 32'h0;
    end
  endfunction

  // Driver: offers a word on a source; the monitor decides the expected order.
  task automatic load(input int c, input logic [31:0] w);
    src[c][src_wp[c] % SD] = w;
    src_wp[c]++;
    refresh();
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [3:0] b);
    @(negedge clk);
    reg_rd = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_be = b;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = a; reg_be = b; reg_wdata = d;
  endtask

  task automatic bus_idle(input int n);
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: reference model checked each cycle before the edge, then advanced.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      int sz;
      bit popping;
      logic [31:0] e;
      logic [NC-1:0] eg;
      string tag;
      sz = exp_q.size();
      chk(irq == ((sz != 0) && en_m), "R7 irq", {31'b0, irq}, {31'b0, (sz != 0) && en_m});
      popping = 0;
      if (reg_rd) begin
        if (reg_be != 4'hF) begin e = 0; tag = "R11 partial read"; end
        else if (reg_addr[7:4] == 4'h8 && reg_addr[1:0] == 0) begin
          e = (sz != 0) ? exp_q[0] : INV;
          tag = (sz != 0) ? "R2 pop read" : "R3 empty pop";
          popping = (sz != 0);
        end
        else if (reg_addr == 8'h90) begin e = (sz != 0) ? exp_q[0] : INV; tag = "R4 peek"; end
        else if (reg_addr == 8'h98) begin
          e = {sz == DP, sz == 0, 22'b0, 8'(sz)}; tag = "R5 status";
        end
        else if (reg_addr == 8'h9C) begin
          e = {27'b0, sz != 0, 3'b0, en_m}; tag = "R6 config";
        end
        else begin e = 0; tag = "R10 unmapped read"; end
        chk(reg_rdata == e, tag, reg_rdata, e);
      end
      if (reg_wr && reg_be == 4'hF && reg_addr == 8'h9C) en_m = reg_wdata[0];
      eg = '0;
      took = -1;
      if (sz < DP || popping) begin
        for (int i = 0; i < NC; i++)
          if (took < 0 && src_wp[i] != src_rp[i]) begin took = i; eg[i] = 1'b1; end
      end
      chk(ch_ready == eg, (sz == DP) ? "R9 take when full" : "R8 source pick",
          {28'b0, ch_ready}, {28'b0, eg});
      if (popping) void'(exp_q.pop_front());
      if (took >= 0) exp_q.push_back(src[took][src_rp[took] % SD]);
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (took >= 0) begin
      src_rp[took]++;
      took = -1;
      refresh();
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_quiet();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ch_valid == '0) break;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin src_wp[i] = 0; src_rp[i] = 0; end
    refresh();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    bus_rd(8'h98, 4'hF); #1;
    chk(reg_rdata == 32'h4000_0000, "R1 reset status", reg_rdata, 32'h4000_0000);
    chk(irq == 1'b0, "R1 reset irq", {31'b0, irq}, 32'h0);
    bus_rd(8'h9C, 4'hF); #1;
    chk(reg_rdata == 32'h0, "R1 reset config", reg_rdata, 32'h0);
    bus_rd(8'h90, 4'hF); #1;
    chk(reg_rdata == INV, "R1 reset slots", reg_rdata, INV);
    // R3: empty removal, twice, then status unchanged
    bus_rd(8'h80, 4'hF);
    bus_rd(8'h8C, 4'hF);
    bus_rd(8'h98, 4'hF);
    bus_idle(1);

    // R8: two sources at once; lowest index first
    load(2, 32'hC200_0001); load(2, 32'hC200_0002); load(2, 32'hC200_0003);
    load(0, 32'hA000_0001); load(0, 32'hA000_0002);
    wait_quiet();
    // R6/R7: enable with all bits set; only bit 0 kept
    bus_wr(8'h9C, 4'hF, 32'hFFFF_FFFF);
    bus_rd(8'h9C, 4'hF);
    bus_rd(8'h90, 4'hF);
    bus_rd(8'h98, 4'hF);
    bus_rd(8'h84, 4'hF);
    bus_rd(8'h90, 4'hF);
    // R11: partial accesses ignored
    bus_rd(8'h80, 4'h7);
    bus_wr(8'h9C, 4'h1, 32'h0);
    bus_rd(8'h9C, 4'hF);
    // R10: unmapped reads and ignored writes
    bus_rd(8'h94, 4'hF);
    bus_rd(8'hA0, 4'hF);
    bus_rd(8'h81, 4'hF);
    bus_wr(8'hA0, 4'hF, 32'h0);
    bus_wr(8'h98, 4'hF, 32'h0);
    bus_rd(8'h98, 4'hF);
    // drain remaining words
    for (int k = 0; k < 5; k++) bus_rd(8'h88, 4'hF);
    bus_rd(8'h90, 4'hF);
    bus_idle(2);

    // R9: overfill one source, then remove while full
    for (int k = 0; k < 12; k++) load(1, 32'hB100_0000 + k);
    load(3, 32'hD300_0000);
    wait_quiet();
    repeat (10) @(negedge clk);
    bus_rd(8'h98, 4'hF);
    for (int k = 0; k < 3; k++) bus_rd(8'h80, 4'hF);
    bus_rd(8'h98, 4'hF);
    bus_idle(3);
    // R7: disable while data waits
    bus_wr(8'h9C, 4'hF, 32'h0);
    bus_idle(2);
    for (int k = 0; k < 16; k++) bus_rd(8'h80, 4'hF);
    bus_rd(8'h98, 4'hF);
    bus_rd(8'h80, 4'hF);
    bus_idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule